// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit is the execute stage of the instruction that sets the active vector length (VL). It receives the decoded instruction fields: a set-length flag, a step-mode flag, a record flag, the indices of the source and destination registers, and a small immediate. It also receives the 64-bit source register value, the 64-bit count register value, and its own maximum vector length (MVL) register. From these it produces the new VL, an optional write-back of that length to the destination register, and a 4-bit condition field that describes the new length.

The length source depends on which of the two register indices are zero. If both are zero, the source is the immediate plus one. If only the source index is zero, the source is the count register. Otherwise the source is the source register value. The requested length is always clamped to MVL. The comparison uses the full 64-bit width, so large values clamp correctly. The condition field describes VL, not the written register. Its overflow bit shows that a length requested from the immediate or the count register was clamped.

The write-back and condition outputs are combinational and are valid in the cycle the instruction is presented. VL and MVL are registers that change on the next rising clock edge. A load port sets MVL, and the loaded value saturates at the architectural ceiling of 64.

Top module: `vlen_set_unit`

## Requirements
- R1: After reset, `vl_q` is 0 and `mvl_q` is 64.
- R2: When `mvl_load` is 1, `mvl_q` becomes min(`mvl_load_val`, 64) at the next edge. A VL that is larger than the new MVL is lowered to the new MVL in the same edge.
- R3: A set is active when `issue_valid`=1, `vs_flag`=1 and `vf_flag`=0. For an active set with source index 0 and destination index nonzero, VL becomes min(MVL, `ctr_val`), `rt_we`=1 and `rt_wdata` equals that length.
- R4: For an active set with both indices 0, VL becomes min(MVL, `imm`+1) and `rt_we`=0.
- R5: For an active set with source index nonzero and destination index 0, VL becomes min(MVL, `ra_val`) and `rt_we`=0.
- R6: For an active set with both indices nonzero, VL becomes min(MVL, `ra_val`), `rt_we`=1 and `rt_wdata` is that length, zero-extended to 64 bits.
- R7: The requested length is compared with MVL over all 64 bits. A value with any bit set above bit 6 clamps to MVL.
- R8: When no set is active, VL does not change (unless R2 lowers it), `rt_we`=0 and `cr_valid`=0.
- R9: `cr_valid` is 1 exactly for an active set with `rc_flag`=1. This includes the case where the destination index is 0.
- R10: The condition field uses bit 3 = LT, bit 2 = GT, bit 1 = EQ and bit 0 = SO. LT is always 0. EQ is 1 when the new VL is 0. GT is 1 when the new VL is nonzero.
- R11: SO is 1 when the request came from the immediate or the count register and exceeded MVL. SO is 0 when the request came from the source register.
- R12: `vl_q` never exceeds `mvl_q`. When a set and an MVL load happen in the same cycle, VL becomes the smaller of the set result (clamped to the old MVL) and the new MVL.

## Ports
| Port | Direction | Width | Description |
| - | - | - | - |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| vs_flag | input | 1 | Set-length flag |
| vf_flag | input | 1 | Step-mode flag; when 1, no set is done |
| rc_flag | input | 1 | Record flag; requests the condition field |
| ra_idx | input | 5 | Source register index |
| rt_idx | input | 5 | Destination register index |
| imm | input | 7 | Immediate; the requested length is imm+1 |
| ra_val | input | 64 | Source register value |
| ctr_val | input | 64 | Count register value |
| mvl_load | input | 1 | Load MVL at the next edge |
| mvl_load_val | input | 7 | MVL value to load (saturates at 64) |
| vl_q | output | 7 | Current vector length |
| mvl_q | output | 7 | Current maximum vector length |
| rt_we | output | 1 | Destination write enable |
| rt_wdata | output | 64 | Destination write data |
| cr_field | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_valid | output | 1 | Condition field is valid |

## Verification
Every combination of zero and nonzero register indices is driven, because the two zero tests are the only thing that selects among the immediate, count-register and source-register paths. Each path is given request values below MVL, equal to MVL, just above MVL and with high bits set. This shows whether the clamp works and whether the comparison sees all 64 bits. These mixes also tell the overflow bit apart by source: the same overflowing request gives SO=1 on the immediate and count paths and SO=0 on the source-register path. MVL loads are mixed in, some in the same cycle as a set, to show that the ceiling of 64 and the lowering of VL interact correctly with the clamp against the old MVL.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_CTR = 2'd1,
    SRC_RA  = 2'd2
  } vl_src_e;

  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;

endpackage

// File: rtl/vlen_src_select.sv
module vlen_src_select
  import vlen_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int IDX_W = 5,
  parameter int IMM_W = 7
) (
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic [LEN_W-1:0] mvl,
  output logic [LEN_W-1:0] new_vl,
  output logic             req_over,
  output vl_src_e          src_kind,
  output logic             rt_sel
);

  function automatic logic [XLEN-1:0] imm_request(input logic [IMM_W-1:0] v);
    return XLEN'(v) + XLEN'(1);
  endfunction

  function automatic logic exceeds(input logic [XLEN-1:0] req, input logic [LEN_W-1:0] lim);
    return req > XLEN'(lim);
  endfunction

  function automatic logic [LEN_W-1:0] clamp(input logic [XLEN-1:0] req, input logic [LEN_W-1:0] lim);
    return exceeds(req, lim) ? lim : req[LEN_W-1:0];
  endfunction

  logic            ra_is_zero;
  logic            rt_is_zero;
  logic [XLEN-1:0] request;

  assign ra_is_zero = (ra_idx == '0);
  assign rt_is_zero = (rt_idx == '0);

  always_comb begin
    if (ra_is_zero && rt_is_zero) begin
      src_kind = SRC_IMM;
      request  = imm_request(imm);
    end else if (ra_is_zero) begin
      src_kind = SRC_CTR;
      request  = ctr_val;
    end else begin
      src_kind = SRC_RA;
      request  = ra_val;
    end
  end

  assign req_over = exceeds(request, mvl);
  assign new_vl   = clamp(request, mvl);
  assign rt_sel   = !rt_is_zero;

endmodule

// File: rtl/vlen_cond_gen.sv
module vlen_cond_gen
  import vlen_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             rc_flag,
  input  logic [LEN_W-1:0] new_vl,
  input  logic             req_over,
  input  vl_src_e          src_kind,
  output logic [3:0]       cr_field,
  output logic             cr_valid
);

  logic so_event;
  logic vl_zero;

  assign vl_zero  = (new_vl == '0);
  assign so_event = req_over && (src_kind != SRC_RA);
  assign cr_valid = active && rc_flag;

  always_comb begin
    cr_field        = '0;
    cr_field[CR_LT] = 1'b0;
    cr_field[CR_GT] = !vl_zero;
    cr_field[CR_EQ] = vl_zero;
    cr_field[CR_SO] = so_event;
  end

  // R10: exactly one of GT and EQ describes the new length
  p_gt_eq_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cr_valid |-> ($countones({cr_field[CR_GT], cr_field[CR_EQ]}) == 1));

  // R11: the overflow bit needs a request that was actually clamped
  p_so_needs_over_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && cr_field[CR_SO]) |-> (new_vl < 7'(64) || req_over));

endmodule

// File: rtl/vlen_state_regs.sv
module vlen_state_regs #(
  parameter int LEN_W     = 7,
  parameter int MAX_LEN   = 64,
  parameter int RESET_MVL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vl_wr,
  input  logic [LEN_W-1:0] vl_wdata,
  input  logic             mvl_load,
  input  logic [LEN_W-1:0] mvl_load_val,
  output logic [LEN_W-1:0] vl_q,
  output logic [LEN_W-1:0] mvl_q
);

  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] RESET_L = LEN_W'(RESET_MVL);

  function automatic logic [LEN_W-1:0] sat_mvl(input logic [LEN_W-1:0] v);
    return (v > MAX_L) ? MAX_L : v;
  endfunction

  function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [LEN_W-1:0] mvl_next;
  logic [LEN_W-1:0] vl_next;

  assign mvl_next = mvl_load ? sat_mvl(mvl_load_val) : mvl_q;

  always_comb begin
    vl_next = vl_q;
    if (vl_wr) vl_next = vl_wdata;
    if (mvl_load) vl_next = min_len(vl_next, mvl_next);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q  <= '0;
      mvl_q <= RESET_L;
    end else begin
      vl_q  <= vl_next;
      mvl_q <= mvl_next;
    end
  end

  p_mvl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_load |=> (mvl_q == (($past(mvl_load_val) > MAX_L) ? MAX_L : $past(mvl_load_val))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vl_wr && !mvl_load) |=> $stable(vl_q));

  p_vl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_wr && !mvl_load) |=> (vl_q == $past(vl_wdata)));

  p_vl_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= mvl_q);

  p_mvl_ceiling_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mvl_q <= MAX_L);

endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
  import vlen_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_W     = 7,
  parameter int IDX_W     = 5,
  parameter int IMM_W     = 7,
  parameter int MAX_LEN   = 64,
  parameter int RESET_MVL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             vs_flag,
  input  logic             vf_flag,
  input  logic             rc_flag,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  ctr_val,
  input  logic             mvl_load,
  input  logic [LEN_W-1:0] mvl_load_val,
  output logic [LEN_W-1:0] vl_q,
  output logic [LEN_W-1:0] mvl_q,
  output logic             rt_we,
  output logic [XLEN-1:0]  rt_wdata,
  output logic [3:0]       cr_field,
  output logic             cr_valid
);

  localparam int PAD_W = XLEN - LEN_W;

  logic             set_active;
  logic [LEN_W-1:0] new_vl;
  logic             req_over;
  vl_src_e          src_kind;
  logic             rt_sel;

  assign set_active = issue_valid && vs_flag && !vf_flag;

  vlen_src_select #(
    .XLEN (XLEN),
    .LEN_W(LEN_W),
    .IDX_W(IDX_W),
    .IMM_W(IMM_W)
  ) u_src (
    .ra_idx  (ra_idx),
    .rt_idx  (rt_idx),
    .imm     (imm),
    .ra_val  (ra_val),
    .ctr_val (ctr_val),
    .mvl     (mvl_q),
    .new_vl  (new_vl),
    .req_over(req_over),
    .src_kind(src_kind),
    .rt_sel  (rt_sel)
  );

  vlen_cond_gen #(
    .LEN_W(LEN_W)
  ) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (set_active),
    .rc_flag (rc_flag),
    .new_vl  (new_vl),
    .req_over(req_over),
    .src_kind(src_kind),
    .cr_field(cr_field),
    .cr_valid(cr_valid)
  );

  vlen_state_regs #(
    .LEN_W    (LEN_W),
    .MAX_LEN  (MAX_LEN),
    .RESET_MVL(RESET_MVL)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .vl_wr       (set_active),
    .vl_wdata    (new_vl),
    .mvl_load    (mvl_load),
    .mvl_load_val(mvl_load_val),
    .vl_q        (vl_q),
    .mvl_q       (mvl_q)
  );

  assign rt_we    = set_active && rt_sel;
  assign rt_wdata = {{PAD_W{1'b0}}, new_vl};

  // R6: the written length is the one that lands in VL
  p_rt_matches_vl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_we && !mvl_load) |=> (vl_q == $past(rt_wdata[LEN_W-1:0])));

  // R10: EQ reported means VL becomes zero
  p_eq_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && cr_field[CR_EQ]) |=> (vl_q == '0));

  // R8: no write-back or condition field without an active set
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!rt_we && !cr_valid));

  // R9: the condition field follows the record flag only
  p_cr_needs_rc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rc_flag |-> !cr_valid);

endmodule

// File: tb/vlen_set_unit_tb_top.sv
`timescale 1ns/1ps
module vlen_set_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_valid, vs_flag, vf_flag, rc_flag;
  logic [4:0]  ra_idx, rt_idx;
  logic [6:0]  imm;
  logic [63:0] ra_val, ctr_val;
  logic        mvl_load;
  logic [6:0]  mvl_load_val;
  logic [6:0]  vl_q, mvl_q;
  logic        rt_we;
  logic [63:0] rt_wdata;
  logic [3:0]  cr_field;
  logic        cr_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int mvl_m    = 64;
  int vl_m     = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vlen_set_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .vs_flag(vs_flag),
    .vf_flag(vf_flag), .rc_flag(rc_flag), .ra_idx(ra_idx), .rt_idx(rt_idx),
    .imm(imm), .ra_val(ra_val), .ctr_val(ctr_val), .mvl_load(mvl_load),
    .mvl_load_val(mvl_load_val), .vl_q(vl_q), .mvl_q(mvl_q), .rt_we(rt_we),
    .rt_wdata(rt_wdata), .cr_field(cr_field), .cr_valid(cr_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_request(input logic [4:0] ra, input logic [4:0] rt,
      input logic [6:0] im, input logic [63:0] rv, input logic [63:0] cv);
    if (ra == 0 && rt == 0) return 64'(im) + 64'd1;
    if (ra == 0) return cv;
    return rv;
  endfunction

  function automatic string mode_tag(input logic [4:0] ra, input logic [4:0] rt);
    if (ra == 0 && rt != 0) return "R3";
    if (ra == 0) return "R4";
    if (rt == 0) return "R5";
    return "R6";
  endfunction

  task automatic op(input bit iv, input bit vs, input bit vf, input bit rc,
                    input logic [4:0] ra, input logic [4:0] rt, input logic [6:0] im,
                    input logic [63:0] rv, input logic [63:0] cv,
                    input bit ld, input logic [6:0] ldv);
    logic [63:0] req;
    int          nvl;
    bit          over, active, from_ra;
    string       tag;
    @(negedge clk);
    issue_valid = iv; vs_flag = vs; vf_flag = vf; rc_flag = rc;
    ra_idx = ra; rt_idx = rt; imm = im; ra_val = rv; ctr_val = cv;
    mvl_load = ld; mvl_load_val = ldv;
    #1;
    active  = iv && vs && !vf;
    req     = ref_request(ra, rt, im, rv, cv);
    over    = req > 64'(mvl_m);
    nvl     = over ? mvl_m : int'(req);
    from_ra = (ra != 0);
    tag     = active ? mode_tag(ra, rt) : "R8";
    check(tag, 64'(rt_we), 64'(active && rt != 0));
    if (active && rt != 0) check(tag, rt_wdata, 64'(nvl));
    check(active ? "R9" : "R8", 64'(cr_valid), 64'(active && rc));
    if (active && rc) begin
      check("R10", 64'(cr_field[3:1]), (nvl == 0) ? 64'b001 : 64'b010);
      check("R11", 64'(cr_field[0]), 64'(over && !from_ra));
    end
    @(posedge clk);
    #1;
    if (active) vl_m = nvl;
    if (ld) begin
      mvl_m = (ldv > 64) ? 64 : int'(ldv);
      if (vl_m > mvl_m) vl_m = mvl_m;
    end
    check(ld ? "R2" : tag, 64'(vl_q), 64'(vl_m));
    check("R2", 64'(mvl_q), 64'(mvl_m));
    check("R12", 64'(vl_q <= mvl_q), 64'd1);
  endtask

  function automatic logic [63:0] rand_val();
    case ($urandom % 5)
      0: return 64'($urandom % 130);
      1: return {$urandom, $urandom};
      2: return 64'd1 << ($urandom % 64);
      3: return 64'(mvl_m) + 64'($urandom % 3);
      default: return 64'(mvl_m) - 64'(($urandom % 2) & (mvl_m > 0 ? 1 : 0));
    endcase
  endfunction

  initial begin
    void'($urandom(32'h1234_5EED));
    rst_n = 1'b0;
    issue_valid = 0; vs_flag = 0; vf_flag = 0; rc_flag = 0;
    ra_idx = 0; rt_idx = 0; imm = 0; ra_val = 0; ctr_val = 0;
    mvl_load = 0; mvl_load_val = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 64'(vl_q), 64'd0);
    check("R1", 64'(mvl_q), 64'd64);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: immediate 127 requests 128, clamps to 64 with SO
    op(1, 1, 0, 1, 5'd0, 5'd0, 7'd127, 64'd0, 64'd0, 0, 7'd0);
    // R4: immediate 9 requests 10, no overflow
    op(1, 1, 0, 1, 5'd0, 5'd0, 7'd9, 64'd0, 64'd0, 0, 7'd0);
    // R3: count register far above MVL
    op(1, 1, 0, 1, 5'd0, 5'd7, 7'd0, 64'd0, 64'h8000_0000_0000_0000, 0, 7'd0);
    // R7: source register with a high bit set and small low bits, no SO (R11)
    op(1, 1, 0, 1, 5'd3, 5'd4, 7'd0, 64'h0000_0001_0000_0005, 64'd0, 0, 7'd0);
    // R5: source register zero gives VL zero and EQ
    op(1, 1, 0, 1, 5'd3, 5'd0, 7'd0, 64'd0, 64'd0, 0, 7'd0);
    // R2: load above the ceiling saturates
    op(0, 0, 0, 0, 5'd0, 5'd0, 7'd0, 64'd0, 64'd0, 1, 7'd100);
    op(1, 1, 0, 0, 5'd1, 5'd2, 7'd0, 64'd64, 64'd0, 0, 7'd0);
    // R2: smaller MVL lowers VL
    op(0, 0, 0, 0, 5'd0, 5'd0, 7'd0, 64'd0, 64'd0, 1, 7'd8);
    // R8: vs clear, vf set, and no issue leave VL alone
    op(1, 0, 0, 1, 5'd1, 5'd1, 7'd0, 64'd2, 64'd0, 0, 7'd0);
    op(1, 1, 1, 1, 5'd1, 5'd1, 7'd0, 64'd2, 64'd0, 0, 7'd0);
    op(0, 1, 0, 1, 5'd1, 5'd1, 7'd0, 64'd2, 64'd0, 0, 7'd0);
    // R12: set against old MVL 8 while loading MVL 3
    op(1, 1, 0, 1, 5'd0, 5'd5, 7'd0, 64'd0, 64'd6, 1, 7'd3);
    // R9: condition field with destination index zero
    op(1, 1, 0, 1, 5'd0, 5'd0, 7'd1, 64'd0, 64'd0, 1, 7'd64);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] ra_r, rt_r;
      ra_r = ($urandom % 2) ? 5'($urandom) : 5'd0;
      rt_r = ($urandom % 2) ? 5'($urandom) : 5'd0;
      op(($urandom % 8) != 0, ($urandom % 6) != 0, ($urandom % 8) == 0, $urandom % 2,
         ra_r, rt_r, 7'($urandom), rand_val(), rand_val(),
         ($urandom % 10) == 0, 7'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule